// File: doc/BRIEF.md
# I2C Serial Byte-Memory Slave

This block is an I2C slave that exposes a 512-byte internal array through one shared address counter. A bus master selects the block with a device byte and may then write a two-byte word address. Ending that write with a stop only repositions the counter. Ending it with a repeated start and a read-direction device byte returns data from the new position at once. A read that skips the address phase continues from wherever the counter currently sits. Every byte the block sends advances the counter by one, and the counter wraps from the top of the array back to zero. As a result, a single read can stream the whole array for as long as the master keeps acknowledging.

SCL and SDA are sampled in the system clock domain. SDA is open drain: the block never drives a one, and only pulls the line low through `sda_oe`. A simple synchronous write port fills the array before bus traffic starts. After a stop, a failed address match or a master NACK, the block ignores all bus activity until it detects a fresh start condition.

Top module: `i2c_seqmem_slave`

## Requirements
- R1: After reset `sda_oe` is 0 and the address counter is 0, so the first current-address read returns the byte at address 0.
- R2: The device byte is {4'b1111, DEV_SEL[2:0], dir} sent MSB first, with dir = 1 meaning read (default DEV_SEL = 3'b111, so 0xFF reads and 0xFE writes). A matching device byte is acknowledged by holding SDA low during the ninth clock.
- R3: A device byte whose upper seven bits differ from that pattern gets no acknowledge. Later bytes clocked without a new start are also not acknowledged, and the counter keeps its value.
- R4: After a write-direction device byte, the block acknowledges two word-address bytes. The counter target is {bit 0 of the first byte, all 8 bits of the second byte}. Bits 7..1 of the first byte have no effect.
- R5: A repeated start followed by a read-direction device byte, sent after the word-address bytes, returns the byte at the loaded address.
- R6: A stop sent directly after the word-address bytes loads the counter without returning data. The next current-address read starts at that address.
- R7: A read-direction device byte sent right after a start returns the byte at the current counter value, with no address phase.
- R8: Each master ACK after a data byte makes the block send the byte at the next address (n, n+1, ...).
- R9: After address 511 the counter wraps to address 0, and data keeps flowing on each ACK.
- R10: The counter also advances after the last byte of a read (the one answered by NACK), so the next current-address read continues at the following address.
- R11: After a stop, bytes clocked without a start are not acknowledged, do not make the block drive SDA, and leave the counter unchanged.
- R12: Data bits are sent MSB first. `sda_oe` changes only while SCL is low, and it is 0 whenever the block is not driving an ACK or a zero data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 9 | Preload byte address |
| pre_data | input | 8 | Preload byte value |

## Verification
The bench targets the address wrap from 0x1FE through 0x000. A design that saturates or sticks at the top of the array returns the wrong third and fourth bytes there. It also checks that the counter moves after the NACKed byte: a design that only counts on ACK would repeat the last byte on the next current-address read. Word-address bytes carry random junk in their ignored upper bits, which exposes any use of those bits. Address mismatches and byte clocking after a stop must draw no acknowledge and must leave the counter alone, which catches a slave that reacts to bus activity while in standby.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  // Fixed device-type nibble in the upper bits of the device byte
  localparam logic [3:0] DEV_TYPE = 4'b1111;

  typedef enum logic [2:0] {
    ST_IDLE,    // standby, waiting for a start
    ST_DEVADR,  // shifting in the device byte
    ST_WA0,     // shifting in word address byte 0
    ST_WA1,     // shifting in word address byte 1
    ST_HOLD,    // address loaded, waiting for restart or stop
    ST_TX,      // sending a data byte
    ST_MACK     // reading the master's ACK/NACK
  } slv_state_e;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  // STAGES synchronizer flops plus one history flop per line
  localparam int PW = STAGES + 1;

  logic [PW-1:0] scl_pipe;
  logic [PW-1:0] sda_pipe;
  logic          scl_p;
  logic          sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[PW-2:0], scl_i};
      sda_pipe <= {sda_pipe[PW-2:0], sda_i};
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];
  assign scl_p = scl_pipe[STAGES];
  assign sda_p = sda_pipe[STAGES];

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // SDA edges count as bus conditions only while SCL stays high
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_byte_array.sv
module i2c_byte_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_mem_pkg::*;
#(
  parameter int         ADDR_W  = 9,
  parameter logic [2:0] DEV_SEL = 3'b111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [7:0]        rdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic              sda_oe
);

  localparam int          HI_W     = ADDR_W - 8;
  localparam logic [3:0]  ACK_SLOT = 4'd8;
  localparam logic [3:0]  LAST_TX  = 4'd7;

  // Counter step, wrapping across the whole array
  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  // Word address: low bits of byte 0 on top of byte 1
  function automatic logic [ADDR_W-1:0] addr_join(input logic [HI_W-1:0] hi,
                                                  input logic [7:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic dev_match(input logic [7:0] b);
    return b[7:1] == {DEV_TYPE, DEV_SEL};
  endfunction

  slv_state_e      state;
  logic [3:0]      bitcnt;
  logic [7:0]      rx_sr;
  logic [6:0]      tx_sr;
  logic [HI_W-1:0] wa_hi_q;
  logic            ack_on;
  logic            mack_q;

  // Named internal events
  logic rx_bit_evt;
  logic ack_edge_evt;
  logic tx_step_evt;
  assign rx_bit_evt   = scl_rise && (bitcnt != ACK_SLOT);
  assign ack_edge_evt = scl_fall && (bitcnt == ACK_SLOT);
  assign tx_step_evt  = scl_fall && (state == ST_TX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      wa_hi_q <= '0;
      ack_on  <= 1'b0;
      mack_q  <= 1'b0;
      addr_q  <= '0;
      sda_oe  <= 1'b0;
    end else if (start_evt) begin
      state  <= ST_DEVADR;
      bitcnt <= '0;
      ack_on <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      ack_on <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_DEVADR, ST_WA0, ST_WA1: begin
          if (rx_bit_evt) begin
            rx_sr  <= {rx_sr[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (ack_edge_evt) begin
            if (!ack_on) begin
              if (state == ST_DEVADR && !dev_match(rx_sr)) begin
                state <= ST_IDLE;
              end else begin
                ack_on <= 1'b1;
                sda_oe <= 1'b1;
              end
            end else begin
              ack_on <= 1'b0;
              bitcnt <= '0;
              if (state == ST_DEVADR) begin
                if (rx_sr[0]) begin
                  state  <= ST_TX;
                  tx_sr  <= rdata[6:0];
                  sda_oe <= ~rdata[7];
                end else begin
                  state  <= ST_WA0;
                  sda_oe <= 1'b0;
                end
              end else if (state == ST_WA0) begin
                wa_hi_q <= rx_sr[HI_W-1:0];
                state   <= ST_WA1;
                sda_oe  <= 1'b0;
              end else begin
                addr_q <= addr_join(wa_hi_q, rx_sr);
                state  <= ST_HOLD;
                sda_oe <= 1'b0;
              end
            end
          end
        end
        ST_TX: begin
          if (tx_step_evt) begin
            if (bitcnt == LAST_TX) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
              mack_q <= 1'b0;
              bitcnt <= '0;
              addr_q <= addr_next(addr_q);
            end else begin
              bitcnt <= bitcnt + 4'd1;
              sda_oe <= ~tx_sr[6];
              tx_sr  <= {tx_sr[5:0], 1'b0};
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              state  <= ST_TX;
              bitcnt <= '0;
              tx_sr  <= rdata[6:0];
              sda_oe <= ~rdata[7];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R12
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!scl_s || $past(start_evt) || $past(stop_evt)));

  // R12
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_HOLD || state == ST_MACK) |-> !sda_oe);

  // R11
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start_evt) |=> (state == ST_IDLE));

  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_DEVADR && bitcnt == 4'd0 && !sda_oe));

  // R8
  addr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q != $past(addr_q)) |-> ($past(state) == ST_TX || $past(state) == ST_WA1));

endmodule

// File: rtl/i2c_seqmem_slave.sv
module i2c_seqmem_slave
  import i2c_mem_pkg::*;
#(
  parameter int         ADDR_W      = 9,
  parameter int         SYNC_STAGES = 2,
  parameter logic [2:0] DEV_SEL     = 3'b111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [7:0]        pre_data
);

  logic              scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        rdata;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_byte_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk   (clk),
    .we    (pre_we),
    .waddr (pre_addr),
    .wdata (pre_data),
    .raddr (addr_q),
    .rdata (rdata)
  );

  i2c_slave_fsm #(.ADDR_W(ADDR_W), .DEV_SEL(DEV_SEL)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .rdata     (rdata),
    .addr_q    (addr_q),
    .sda_oe    (sda_oe)
  );

endmodule

// File: tb/tb_i2c_seqmem_slave.sv
`timescale 1ns/1ps
module tb_i2c_seqmem_slave;

  localparam int Q = 8;       // clocks per quarter SCL period
  localparam int AW = 9;
  localparam int DEPTH = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [7:0] pre_data = '0;
  wire sda_line = sda_m & ~sda_oe;

  int n_tests = 0;
  int n_fail = 0;
  int oe_viol = 0;
  logic oe_prev = 1'b0;

  logic [7:0]    bmem [DEPTH];
  logic [AW-1:0] cur;

  always #2 clk = ~clk;

  i2c_seqmem_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data)
  );

  // R12 monitor: output enable may move only while the bench holds SCL low
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && scl_m) oe_viol++;
    oe_prev <= sda_oe;
  end

  function automatic logic [AW-1:0] ref_join(input logic [7:0] b0, input logic [7:0] b1);
    logic [AW-1:0] r;
    r = {b0[0], b1};
    return r;
  endfunction

  function automatic logic [AW-1:0] ref_next(input logic [AW-1:0] a);
    return (int'(a) == DEPTH - 1) ? '0 : AW'(int'(a) + 1);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    chk8(req, {7'd0, act}, {7'd0, exp});
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_restart();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_line;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = ~mack; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic read_bytes(input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk8(req, b, bmem[cur]);
      cur = ref_next(cur);
    end
  endtask

  task automatic dummy_write(input logic [AW-1:0] a);
    logic ack;
    logic [7:0] b0;
    b0 = {7'($urandom), a[8]};   // junk in the ignored upper bits
    i2c_start();
    send_byte(8'hFE, ack); chk1("R2 write device byte ack", ack, 1'b1);
    send_byte(b0, ack);    chk1("R4 word address 0 ack", ack, 1'b1);
    send_byte(a[7:0], ack); chk1("R4 word address 1 ack", ack, 1'b1);
    cur = ref_join(b0, a[7:0]);
  endtask

  task automatic random_read(input logic [AW-1:0] a, input int n, input string req);
    logic ack;
    dummy_write(a);
    i2c_restart();
    send_byte(8'hFF, ack); chk1("R5 read device byte ack", ack, 1'b1);
    read_bytes(n, req);
    i2c_stop();
  endtask

  task automatic current_read(input int n, input string req);
    logic ack;
    i2c_start();
    send_byte(8'hFF, ack); chk1("R7 read device byte ack", ack, 1'b1);
    read_bytes(n, req);
    i2c_stop();
  endtask

  initial begin
    #(200000 * 4);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    void'($urandom(32'd1234));
    tick(10);
    rst_n = 1'b1;
    tick(2);
    chk1("R1 sda_oe after reset", sda_oe, 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      bmem[i] = 8'($urandom);
      pre_we = 1'b1; pre_addr = AW'(i); pre_data = bmem[i];
      tick(1);
    end
    pre_we = 1'b0;
    tick(4);
    cur = '0;

    // R1 / R7: first current read from address 0, then R10 continuation
    current_read(1, "R1 first read at address 0");
    current_read(2, "R10 continue after NACK");

    // R3: mismatched device byte, then bytes without start
    i2c_start();
    send_byte(8'hF5, ack); chk1("R3 mismatch no ack", ack, 1'b0);
    send_byte(8'hFF, ack); chk1("R3 later byte ignored", ack, 1'b0);
    i2c_stop();
    chk1("R12 released after stop", sda_oe, 1'b0);
    current_read(1, "R3 counter unchanged");

    // R4 / R5: random read with junk upper bits in word byte 0
    random_read(9'h123, 1, "R5 random read");
    current_read(1, "R10 after random read");

    // R6: set address then stop
    dummy_write(9'h040);
    i2c_stop();
    current_read(1, "R6 set address then stop");

    // R8: sequential read
    random_read(9'h0A7, 5, "R8 sequential read");

    // R9: wrap across the top of the array
    random_read(9'h1FE, 4, "R9 wrap to zero");
    current_read(1, "R9 continue after wrap");

    // R11: bytes clocked after a stop with no start
    send_byte(8'hFF, ack); chk1("R11 no ack in standby", ack, 1'b0);
    recv_byte(1'b0, b);    chk8("R11 line released in standby", b, 8'hFF);
    chk1("R11 sda_oe low in standby", sda_oe, 1'b0);
    current_read(1, "R11 counter unchanged");

    // Constrained random mix
    for (int it = 0; it < 24; it++) begin
      int op;
      op = int'($urandom % 3);
      if (op == 0) begin
        random_read(AW'($urandom), 1 + int'($urandom % 4), "R8 random sequential");
      end else if (op == 1) begin
        current_read(1 + int'($urandom % 3), "R7 random current read");
      end else begin
        dummy_write(AW'($urandom));
        i2c_stop();
        current_read(1, "R6 random set address");
      end
    end

    n_tests++;
    if (oe_viol != 0) begin
      n_fail++;
      $display("FAIL R12 oe changes while SCL high actual=%0d expected=0", oe_viol);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule